// File: doc/BRIEF.md
# Serial Controller Interrupt Enable and Request Router

This block holds the interrupt-enable register of a serial controller that runs either as a plain asynchronous UART (SCI-compatible mode) or as a LIN bus node. Software writes the register through a simple write port. A write only sets bits and never clears them. The register can be read back at any time. The `lin_mode` input selects the operating mode. That choice decides which enable bits can be written and which of them take part in raising an interrupt.

The serial core sends single-cycle event pulses into the block. These cover error conditions, receive-frame completion (tagged as an address frame or a data frame), transmit-buffer ready, identifier match, the three timeout kinds, wake-up conditions and break detection. Each event that is not routed to DMA sets a sticky flag. The flag stays set until the matching bit of `flag_clr` is driven, and that input stands in for the separate clear register. Receive and transmit events can instead go out as one-cycle DMA requests, depending on the DMA enable bits. A receive frame can be split so that address frames go to the interrupt path and data frames go to DMA.

Top module: `sci_irq_router`

## Requirements
- R1: While `rst_n` is low, and right after it, every enable bit reads 0, and `irq`, `rx_dma_req` and `tx_dma_req` are 0.
- R2: A write makes each enable bit whose `wr_data` bit is 1 read back as 1 from the next cycle, provided that bit is writable in the current mode. A 0 in `wr_data` never clears an enable bit. Only reset clears them.
- R3: Bit positions 23..19, 15..14, 12..10, 5, 3 and 2 always read 0, whatever is written.
- R4: Enables for bit error (31), physical bus error (30), checksum (29), sync-field inconsistency (28), no-response (27), identifier match (13), timeout after three wake-ups (7), timeout after one wake-up (6) and bus-idle timeout (4) can be written only while `lin_mode` is 1. Writes to these bits are ignored while `lin_mode` is 0.
- R5: The break-detect enable (bit 0) can be written only while `lin_mode` is 0.
- R6: Each event sets a flag at the same bit position as its enable. The flag holds until `flag_clr` is 1 at that position. An event in the same cycle as a clear leaves the flag set. `irq` is the OR, over all positions, of flag AND enable AND the bit being effective in the current mode.
- R7: In SCI-compatible mode the bits listed in R4 do not contribute to `irq`. In LIN mode bit 0 does not contribute. Flags stay latched when the mode changes.
- R8: While RX-DMA (bit 17) is 0, a received frame sets the RX flag (bit 9), which raises `irq` only when the RX enable (bit 9) is 1. While TX-DMA (bit 16) is 0, `tx_rdy` sets the TX flag (bit 8), gated by the TX enable (bit 8).
- R9: With bit 17 set and RX-DMA-all (bit 18) clear, an address frame (`rx_addr`=1) sets the RX flag and a data frame produces a one-cycle `rx_dma_req` in the next cycle. With bits 17 and 18 both set, every frame produces `rx_dma_req` and no flag.
- R10: With bit 16 set, `tx_rdy` produces a one-cycle `tx_dma_req` in the next cycle and does not set the TX flag.
- R11: The wake-up flag (bit 1) is set when `lp_active` and `rx_low` are both 1, or when `lp_req` and `rx_busy` are both 1. A low receive level outside low-power mode sets nothing.
- R12: A register write and an event in the same cycle both take effect, so `irq` can rise in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lin_mode | input | 1 | 1 = LIN mode, 0 = SCI-compatible mode |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data, 1 sets an enable |
| rd_data | output | 32 | Enable register read-back |
| err_evt | input | 8 | Error event pulses, index i maps to bit 24+i |
| rx_done | input | 1 | Receive frame complete pulse |
| rx_addr | input | 1 | Completed frame is an address frame |
| tx_rdy | input | 1 | Transmit buffer ready pulse |
| id_match | input | 1 | Identifier match pulse |
| to3_wake | input | 1 | Timeout after three wake-ups pulse |
| to1_wake | input | 1 | Timeout after one wake-up pulse |
| idle_to | input | 1 | Bus-idle timeout pulse |
| brk_det | input | 1 | Break detected pulse |
| lp_active | input | 1 | Block is in low-power mode |
| lp_req | input | 1 | Low-power mode is being requested |
| rx_busy | input | 1 | Receiver is busy |
| rx_low | input | 1 | Receive pin is at low level |
| flag_clr | input | 32 | Per-bit flag clear |
| irq | output | 1 | Interrupt request |
| rx_dma_req | output | 1 | Receive DMA request pulse |
| tx_dma_req | output | 1 | Transmit DMA request pulse |

## Verification
The hardest state to reach is a latched flag whose enable is set but not effective in the current mode, followed by a mode change that makes it effective. That needs a write in one mode, an event, and then a mode flip with no clear in between. The bench reaches it with directed sequences for each mode-restricted class. It also runs a long random phase where mode flips are rare and clears are sparse, so flags survive across mode changes. Address and data frames are interleaved under every combination of the two receive DMA bits.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int REG_W   = 32;
  localparam int ERR_N   = 8;
  localparam int ERR_LSB = 24;

  localparam int B_RXDMA_ALL = 18;
  localparam int B_RXDMA     = 17;
  localparam int B_TXDMA     = 16;
  localparam int B_IDM       = 13;
  localparam int B_RX        = 9;
  localparam int B_TX        = 8;
  localparam int B_TO3       = 7;
  localparam int B_TO1       = 6;
  localparam int B_IDLE      = 4;
  localparam int B_WAKE      = 1;
  localparam int B_BRK       = 0;

  // implemented bits, mode-restricted classes, DMA controls
  localparam logic [REG_W-1:0] M_IMPL     = 32'hFF07_23D3;
  localparam logic [REG_W-1:0] M_LIN_ONLY = 32'hF800_20D0;
  localparam logic [REG_W-1:0] M_SCI_ONLY = 32'h0000_0001;
  localparam logic [REG_W-1:0] M_DMA      = 32'h0007_0000;
  localparam logic [REG_W-1:0] M_FLAG     = M_IMPL & ~M_DMA;

  function automatic logic [REG_W-1:0] wr_mask(input logic lin);
    return lin ? (M_IMPL & ~M_SCI_ONLY) : (M_IMPL & ~M_LIN_ONLY);
  endfunction

  function automatic logic [REG_W-1:0] eff_mask(input logic lin);
    return lin ? ~M_SCI_ONLY : ~M_LIN_ONLY;
  endfunction
endpackage

// File: rtl/sirq_enable_reg.sv
module sirq_enable_reg
  import sirq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         lin_mode,
  output logic [W-1:0] en_q
);
  logic [W-1:0] en_d;
  logic         en_ce;

  always_comb begin
    en_ce = wr_en;
    en_d  = en_q | (wr_data & W'(wr_mask(lin_mode)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  // R2: enables only ever rise outside reset
  a_r2_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(en_q) & ~en_q) == '0));
  // R3: reserved positions stay zero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & ~W'(M_IMPL)) == '0));
  // R4: LIN-only enables locked in SCI-compatible mode
  a_r4_lin_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lin_mode) |=> ((en_q & W'(M_LIN_ONLY)) == ($past(en_q) & W'(M_LIN_ONLY))));
  // R5: break enable locked in LIN mode
  a_r5_brk_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lin_mode) |=> (en_q[B_BRK] == $past(en_q[B_BRK])));
endmodule

// File: rtl/sirq_event_flags.sv
module sirq_event_flags
  import sirq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flag_q
);
  localparam logic [W-1:0] FLAG_BITS = W'(M_FLAG);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (FLAG_BITS[i]) begin : g_flag
      logic flag_d;

      always_comb flag_d = set_vec[i] | (flag_q[i] & ~clr_vec[i]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[i] <= 1'b0;
        else        flag_q[i] <= flag_d;
      end

      // R6: a flag holds without set or clear
      a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_vec[i] && !clr_vec[i]) |=> (flag_q[i] == $past(flag_q[i])));
      // R6: set wins over a same-cycle clear
      a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[i] |=> flag_q[i]);
    end else begin : g_none
      assign flag_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sirq_req_route.sv
module sirq_req_route (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_done,
  input  logic rx_addr,
  input  logic tx_rdy,
  input  logic dma_rx_en,
  input  logic dma_rx_all,
  input  logic dma_tx_en,
  output logic rx_flag_set,
  output logic tx_flag_set,
  output logic rx_dma_req,
  output logic tx_dma_req
);
  logic rx_to_dma, tx_to_dma;

  always_comb begin
    rx_to_dma   = rx_done & dma_rx_en & (dma_rx_all | ~rx_addr);
    tx_to_dma   = tx_rdy & dma_tx_en;
    rx_flag_set = rx_done & ~rx_to_dma;
    tx_flag_set = tx_rdy & ~tx_to_dma;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_dma_req <= 1'b0;
      tx_dma_req <= 1'b0;
    end else begin
      rx_dma_req <= rx_to_dma;
      tx_dma_req <= tx_to_dma;
    end
  end

  // R9: data frame under RX-DMA is a request next cycle
  a_r9_data_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_addr && dma_rx_en) |=> rx_dma_req);
  // R9: address frame without RX-DMA-all never requests DMA
  a_r9_addr_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_addr && !dma_rx_all) |=> !rx_dma_req);
  // R9: a request always traces back to a frame
  a_r9_src: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> $past(rx_done));
  // R10: transmit DMA routing
  a_r10_tx_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rdy && dma_tx_en) |=> tx_dma_req);
endmodule

// File: rtl/sci_irq_router.sv
module sci_irq_router
  import sirq_pkg::*;
#(
  parameter int W     = REG_W,
  parameter int N_ERR = ERR_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lin_mode,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     rd_data,
  input  logic [N_ERR-1:0] err_evt,
  input  logic             rx_done,
  input  logic             rx_addr,
  input  logic             tx_rdy,
  input  logic             id_match,
  input  logic             to3_wake,
  input  logic             to1_wake,
  input  logic             idle_to,
  input  logic             brk_det,
  input  logic             lp_active,
  input  logic             lp_req,
  input  logic             rx_busy,
  input  logic             rx_low,
  input  logic [W-1:0]     flag_clr,
  output logic             irq,
  output logic             rx_dma_req,
  output logic             tx_dma_req
);
  logic [W-1:0] en_q;
  logic [W-1:0] flag_q;
  logic [W-1:0] set_vec;
  logic         rx_flag_set, tx_flag_set;
  logic         wake_evt;

  sirq_enable_reg #(.W(W)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .lin_mode(lin_mode), .en_q(en_q)
  );

  sirq_req_route u_route (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_addr(rx_addr),
    .tx_rdy(tx_rdy), .dma_rx_en(en_q[B_RXDMA]), .dma_rx_all(en_q[B_RXDMA_ALL]),
    .dma_tx_en(en_q[B_TXDMA]), .rx_flag_set(rx_flag_set),
    .tx_flag_set(tx_flag_set), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
  );

  always_comb begin
    wake_evt = (lp_active & rx_low) | (lp_req & rx_busy);
    set_vec  = '0;
    set_vec[ERR_LSB +: N_ERR] = err_evt;
    set_vec[B_IDM]  = id_match;
    set_vec[B_RX]   = rx_flag_set;
    set_vec[B_TX]   = tx_flag_set;
    set_vec[B_TO3]  = to3_wake;
    set_vec[B_TO1]  = to1_wake;
    set_vec[B_IDLE] = idle_to;
    set_vec[B_WAKE] = wake_evt;
    set_vec[B_BRK]  = brk_det;
  end

  sirq_event_flags #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(flag_clr),
    .flag_q(flag_q)
  );

  always_comb begin
    rd_data = en_q;
    irq     = |(flag_q & en_q & W'(eff_mask(lin_mode)));
  end

  // R11: wake flag rises only from a qualifying condition
  a_r11_wake_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[B_WAKE]) |-> $past((lp_active && rx_low) || (lp_req && rx_busy)));
  // R7: break enable has no say in LIN mode
  a_r7_brk_lin: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_mode && ((flag_q & en_q & ~W'(M_SCI_ONLY)) == '0)) |-> !irq);
  // R9: a DMA-routed frame does not set the RX flag
  a_r9_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && en_q[B_RXDMA] && en_q[B_RXDMA_ALL] && !flag_q[B_RX]) |=> !flag_q[B_RX]);
endmodule

// File: tb/sci_irq_router_test.sv
`timescale 1ns/1ps
module sci_irq_router_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lin_mode, wr_en, rx_done, rx_addr, tx_rdy, id_match;
  logic        to3_wake, to1_wake, idle_to, brk_det;
  logic        lp_active, lp_req, rx_busy, rx_low;
  logic [31:0] wr_data, flag_clr, rd_data;
  logic [7:0]  err_evt;
  logic        irq, rx_dma_req, tx_dma_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_en, m_fl;
  logic        m_rxd, m_txd;

  always #5 clk = ~clk;

  sci_irq_router uut (
    .clk(clk), .rst_n(rst_n), .lin_mode(lin_mode), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .err_evt(err_evt),
    .rx_done(rx_done), .rx_addr(rx_addr), .tx_rdy(tx_rdy),
    .id_match(id_match), .to3_wake(to3_wake), .to1_wake(to1_wake),
    .idle_to(idle_to), .brk_det(brk_det), .lp_active(lp_active),
    .lp_req(lp_req), .rx_busy(rx_busy), .rx_low(rx_low),
    .flag_clr(flag_clr), .irq(irq), .rx_dma_req(rx_dma_req),
    .tx_dma_req(tx_dma_req)
  );

  function automatic logic [31:0] f_wmask(input logic lin);
    return lin ? 32'hFF07_23D2 : 32'h0707_0303;
  endfunction

  function automatic logic [31:0] f_eff(input logic lin);
    return lin ? 32'hFFFF_FFFE : 32'h07FF_DF2F;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_data = '0; err_evt = '0; rx_done = 0; rx_addr = 0;
    tx_rdy = 0; id_match = 0; to3_wake = 0; to1_wake = 0; idle_to = 0;
    brk_det = 0; lp_active = 0; lp_req = 0; rx_busy = 0; rx_low = 0;
    flag_clr = '0;
  endtask

  // one clock: model update at the edge, compare 1 ns later
  task automatic step(input string ctx);
    logic [31:0] set_v, en_n;
    logic        rxd, txd, wake;
    @(posedge clk);
    rxd  = rx_done & m_en[17] & (m_en[18] | ~rx_addr);
    txd  = tx_rdy & m_en[16];
    wake = (lp_active & rx_low) | (lp_req & rx_busy);
    set_v = {err_evt, 24'h0};
    set_v[13] = id_match;
    set_v[9]  = rx_done & ~rxd;
    set_v[8]  = tx_rdy & ~txd;
    set_v[7]  = to3_wake;
    set_v[6]  = to1_wake;
    set_v[4]  = idle_to;
    set_v[1]  = wake;
    set_v[0]  = brk_det;
    en_n  = m_en | (wr_en ? (wr_data & f_wmask(lin_mode)) : 32'h0);
    m_fl  = (m_fl & ~flag_clr) | set_v;
    m_en  = en_n;
    m_rxd = rxd;
    m_txd = txd;
    #1;
    chk(rd_data, m_en, {ctx, " R2 readback"});
    chk({31'h0, irq}, {31'h0, |(m_fl & m_en & f_eff(lin_mode))}, {ctx, " R6 irq"});
    chk({31'h0, rx_dma_req}, {31'h0, m_rxd}, {ctx, " R9 rx dma"});
    chk({31'h0, tx_dma_req}, {31'h0, m_txd}, {ctx, " R10 tx dma"});
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle_inputs();
    m_en = '0; m_fl = '0; m_rxd = 0; m_txd = 0;
    @(posedge clk); #1;
    chk(rd_data, 32'h0, "R1 reset enables");
    chk({29'h0, irq, rx_dma_req, tx_dma_req}, 32'h0, "R1 reset outputs");
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; lin_mode = 1; idle_inputs();
    m_en = '0; m_fl = '0; m_rxd = 0; m_txd = 0;
    repeat (2) @(posedge clk);

    // R3 / R5: write all ones in LIN mode
    do_reset(); lin_mode = 1;
    wr_en = 1; wr_data = 32'hFFFF_FFFF; step("R3 R5 all ones LIN");
    chk(rd_data, 32'hFF07_23D2, "R3 reserved and break bit after LIN write");

    // R4: write all ones in SCI mode
    do_reset(); lin_mode = 0;
    wr_en = 1; wr_data = 32'hFFFF_FFFF; step("R4 all ones SCI");
    chk(rd_data, 32'h0707_0303, "R4 LIN-only bits blocked in SCI");
    wr_en = 1; wr_data = 32'h0; step("R2 zero write");
    chk(rd_data, 32'h0707_0303, "R2 zero write leaves enables");

    // R8: RX interrupt path
    do_reset(); lin_mode = 1;
    rx_done = 1; step("R8 rx with enable clear");
    chk({31'h0, irq}, 32'h0, "R8 no irq while RX enable clear");
    wr_en = 1; wr_data = 32'h200; step("R8 late enable sees held flag");
    chk({31'h0, irq}, 32'h1, "R8 held RX flag raises irq");
    flag_clr = 32'h200; step("R6 clear RX flag");
    chk({31'h0, irq}, 32'h0, "R6 cleared flag drops irq");
    tx_rdy = 1; step("R8 tx flag with TX enable clear");
    wr_en = 1; wr_data = 32'h100; step("R8 TX enable");

    // R9: RX DMA split
    do_reset(); lin_mode = 0;
    wr_en = 1; wr_data = 32'h0002_0200; step("R9 setup");
    rx_done = 1; rx_addr = 1; step("R9 address frame to irq");
    chk({30'h0, irq, rx_dma_req}, 32'h2, "R9 address frame irq not dma");
    flag_clr = 32'h200; rx_done = 1; rx_addr = 0; step("R9 data frame to dma");
    chk({30'h0, irq, rx_dma_req}, 32'h1, "R9 data frame dma not irq");
    step("R9 pulse ends");
    chk({31'h0, rx_dma_req}, 32'h0, "R9 dma single cycle");
    wr_en = 1; wr_data = 32'h0004_0000; step("R9 set all");
    rx_done = 1; rx_addr = 1; step("R9 all address frame");
    chk({30'h0, irq, rx_dma_req}, 32'h1, "R9 all routes address to dma");

    // R10: TX DMA
    do_reset(); lin_mode = 1;
    wr_en = 1; wr_data = 32'h0001_0100; step("R10 setup");
    tx_rdy = 1; step("R10 tx to dma");
    chk({30'h0, irq, tx_dma_req}, 32'h1, "R10 dma only");
    step("R10 pulse ends");

    // R11: wake-up
    do_reset(); lin_mode = 0;
    wr_en = 1; wr_data = 32'h2; step("R11 setup");
    rx_low = 1; step("R11 low outside low power");
    chk({31'h0, irq}, 32'h0, "R11 no wake outside low power");
    lp_active = 1; rx_low = 1; step("R11 low in low power");
    chk({31'h0, irq}, 32'h1, "R11 wake in low power");
    flag_clr = 32'h2; lp_req = 1; rx_busy = 1; step("R11 request while busy");
    chk({31'h0, irq}, 32'h1, "R11 wake on request while busy");
    flag_clr = 32'h2; lp_req = 1; step("R11 request while idle");
    chk({31'h0, irq}, 32'h0, "R11 no wake when receiver idle");

    // R7: mode effectiveness
    do_reset(); lin_mode = 1;
    wr_en = 1; wr_data = 32'h8000_0000; step("R7 setup");
    err_evt = 8'h80; step("R7 bit error in LIN");
    chk({31'h0, irq}, 32'h1, "R7 LIN-only irq in LIN");
    lin_mode = 0; step("R7 switch to SCI");
    chk({31'h0, irq}, 32'h0, "R7 LIN-only ignored in SCI");
    lin_mode = 1; step("R7 back to LIN");
    chk({31'h0, irq}, 32'h1, "R7 flag kept across mode");
    lin_mode = 0; flag_clr = 32'h8000_0000; wr_en = 1; wr_data = 32'h1; step("R5 break enable SCI");
    lin_mode = 0; brk_det = 1; step("R7 break in SCI");
    chk({31'h0, irq}, 32'h1, "R7 break irq in SCI");
    lin_mode = 1; step("R7 break in LIN");
    chk({31'h0, irq}, 32'h0, "R7 break ignored in LIN");

    // R12 and R6 same-cycle cases
    do_reset(); lin_mode = 1;
    wr_en = 1; wr_data = 32'h2000; id_match = 1; step("R12 write with event");
    chk({31'h0, irq}, 32'h1, "R12 write and event same cycle");
    id_match = 1; flag_clr = 32'h2000; step("R6 set wins over clear");
    chk({31'h0, irq}, 32'h1, "R6 set beats clear");

    // random phase
    do_reset(); lin_mode = 1;
    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 64 == 0) lin_mode = ~lin_mode;
      if ($urandom % 10 == 0) begin
        wr_en = 1;
        wr_data = $urandom & $urandom;
      end
      if ($urandom % 6 == 0) err_evt = 8'(1 << ($urandom % 8));
      rx_done  = ($urandom % 4 == 0);
      rx_addr  = $urandom % 2;
      tx_rdy   = ($urandom % 5 == 0);
      id_match = ($urandom % 12 == 0);
      to3_wake = ($urandom % 20 == 0);
      to1_wake = ($urandom % 20 == 0);
      idle_to  = ($urandom % 20 == 0);
      brk_det  = ($urandom % 15 == 0);
      lp_active = $urandom % 2;
      rx_low    = ($urandom % 8 == 0);
      lp_req    = ($urandom % 8 == 0);
      rx_busy   = $urandom % 2;
      if ($urandom % 5 == 0) flag_clr = $urandom;
      if ($urandom % 500 == 0) begin
        do_reset();
      end else begin
        step("R6 random");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule